// File: doc/BRIEF.md
# Two-Channel Masked Calendar Alarm

This block watches a calendar time that an external timekeeping counter supplies and raises an alarm when that time matches one of two programmed alarm settings. The counter provides six BCD bytes: second, minute, hour, weekday, day of month and month. It also provides a single-cycle strobe once per second. Each alarm channel holds six compare bytes and a control byte. The control byte carries a per-field enable mask, a repeat/single-shot choice and an arm bit.

A match sets a sticky per-channel flag. The host can poll the flag, or route it to a shared active-low pin through a per-channel interrupt enable. The host clears a flag by writing 1 to it. A configuration bit gives the same pin to a divided clock input instead. In that mode the flags still update but no longer drive the pin.

All configuration goes through a single-cycle write port. Channel `k` occupies offsets `k*8+0..k*8+6`, and two global registers follow the channel blocks.

Top module: `cal_alarm_top`

## Requirements
- R1: After reset, every flag and arm bit is 0, every mask is empty, the pin select is interrupt mode and `irq_fout_n` is 1 (released).
- R2: Writing offset `k*8+f` (f = 0 second, 1 minute, 2 hour, 3 weekday, 4 date, 5 month) loads compare byte f of channel k. Writing offset `k*8+6` loads the control byte: bits 5:0 are the field enables in the same field order, bit 6 is repeat and bit 7 is arm.
- R3: A channel's flag is set at the clock edge where `sec_tick` is 1, the channel is armed, and every enabled field equals its compare byte. Disabled fields are ignored. Without `sec_tick` no flag is set.
- R4: A channel whose field mask is all zero never sets its flag.
- R5: In single-shot mode (repeat = 0) the arm bit clears at the edge where the flag is set, so later matches do not fire. In repeat mode the channel stays armed and fires again on each qualifying strobe.
- R6: Flags are sticky. Writing the status offset (`N_ALARMS*8+1`) with bit k = 1 clears flag k. If a match and a clear happen at the same edge, the set wins.
- R7: The configuration offset (`N_ALARMS*8`) holds bit 0 = pin select (0 = interrupt, 1 = frequency) and bit 1+k = interrupt enable for channel k. In interrupt mode `irq_fout_n` is 0 one cycle after any enabled flag is 1, and 1 when no enabled flag is set.
- R8: In frequency mode `irq_fout_n` equals `freq_in` delayed by one cycle, and flags keep updating as in R3.
- R9: The two channels are independent: a match, clear or disarm on one channel leaves the other unchanged.
- R10: A channel whose arm bit is 0 never sets its flag, even when its enabled fields all match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle strobe per second from the time counter |
| now_sec | input | 8 | Current second, BCD |
| now_min | input | 8 | Current minute, BCD |
| now_hour | input | 8 | Current hour, BCD |
| now_wday | input | 8 | Current weekday |
| now_date | input | 8 | Current day of month, BCD |
| now_month | input | 8 | Current month, BCD |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write offset |
| wr_data | input | 8 | Register write data |
| freq_in | input | 1 | Divided clock for frequency-output mode |
| irq_fout_n | output | 1 | Shared active-low interrupt / frequency pin (registered) |
| alarm_flag | output | 2 | Sticky per-channel match flags for polling |
| alarm_armed | output | 2 | Per-channel arm state |

## Verification
The assertions assume that `sec_tick` lasts exactly one cycle. They also assume that the calendar bytes are stable while it is high, and that `wr_en` is the only way the host changes state. The single-shot check further assumes that no write coincides with a firing strobe. The bench drives every input on the falling edge and raises `sec_tick` for exactly one cycle. It keeps writes and strobes in separate cycles, except in the one deliberate set-versus-clear collision. That collision is the only point where a status write and a match share an edge.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  localparam int FIELD_W  = 8;
  localparam int N_FIELDS = 6;
  localparam int OFF_W    = $clog2(N_FIELDS + 2);
  localparam int CTRL_RPT = N_FIELDS;
  localparam int CTRL_ARM = N_FIELDS + 1;

  typedef enum logic {PIN_IRQ = 1'b0, PIN_FREQ = 1'b1} pin_mode_e;
endpackage

// File: rtl/cal_alarm_unit.sv
module cal_alarm_unit
  import cal_alarm_pkg::*;
#(
  parameter int IDX    = 0,
  parameter int ADDR_W = 5
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         tick,
  input  logic [N_FIELDS*FIELD_W-1:0]  now_flat,
  input  logic                         wr_en,
  input  logic [ADDR_W-1:0]            wr_addr,
  input  logic [FIELD_W-1:0]           wr_data,
  input  logic                         clr_req,
  output logic                         flag,
  output logic                         armed,
  output logic                         rpt,
  output logic [N_FIELDS-1:0]          mask
);
  localparam int SEL_W = ADDR_W - OFF_W;

  logic [FIELD_W-1:0] cmp_q [N_FIELDS];
  logic               sel;
  logic [OFF_W-1:0]   off;
  logic               all_eq;
  logic               fire;

  assign off = wr_addr[OFF_W-1:0];
  assign sel = wr_en && (wr_addr[ADDR_W-1:OFF_W] == SEL_W'(IDX));

  always_comb begin
    all_eq = 1'b1;
    for (int f = 0; f < N_FIELDS; f++) begin
      if (mask[f] && (cmp_q[f] != now_flat[f*FIELD_W +: FIELD_W]))
        all_eq = 1'b0;
    end
  end

  assign fire = tick && armed && (|mask) && all_eq;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int f = 0; f < N_FIELDS; f++) cmp_q[f] <= '0;
    end else if (sel && (int'(off) < N_FIELDS)) begin
      cmp_q[off] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask  <= '0;
      rpt   <= 1'b0;
      armed <= 1'b0;
      flag  <= 1'b0;
    end else begin
      if (sel && (int'(off) == N_FIELDS)) begin
        mask  <= wr_data[N_FIELDS-1:0];
        rpt   <= wr_data[CTRL_RPT];
        armed <= wr_data[CTRL_ARM];
      end else if (fire && !rpt) begin
        armed <= 1'b0;
      end
      if (fire)
        flag <= 1'b1;
      else if (clr_req)
        flag <= 1'b0;
    end
  end
endmodule

// File: rtl/cal_pin_drive.sv
module cal_pin_drive
  import cal_alarm_pkg::*;
#(
  parameter int N_ALARMS = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  pin_mode_e           mode,
  input  logic [N_ALARMS-1:0] flags,
  input  logic [N_ALARMS-1:0] ien,
  input  logic                freq_in,
  output logic                pin_n
);
  always_ff @(posedge clk) begin
    if (rst)
      pin_n <= 1'b1;
    else if (mode == PIN_FREQ)
      pin_n <= freq_in;
    else
      pin_n <= ~|(flags & ien);
  end
endmodule

// File: rtl/cal_alarm_top.sv
module cal_alarm_top
  import cal_alarm_pkg::*;
#(
  parameter int N_ALARMS = 2,
  parameter int ADDR_W   = 5
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                sec_tick,
  input  logic [7:0]          now_sec,
  input  logic [7:0]          now_min,
  input  logic [7:0]          now_hour,
  input  logic [7:0]          now_wday,
  input  logic [7:0]          now_date,
  input  logic [7:0]          now_month,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [7:0]          wr_data,
  input  logic                freq_in,
  output logic                irq_fout_n,
  output logic [N_ALARMS-1:0] alarm_flag,
  output logic [N_ALARMS-1:0] alarm_armed
);
  localparam int CFG_ADDR  = N_ALARMS << OFF_W;
  localparam int STAT_ADDR = CFG_ADDR + 1;

  logic [N_FIELDS*FIELD_W-1:0] now_flat;
  pin_mode_e                   mode_q;
  logic [N_ALARMS-1:0]         ien_q;
  logic [N_ALARMS-1:0]         clr_vec;
  logic [N_ALARMS-1:0]         rpt_vec;
  logic [N_ALARMS*N_FIELDS-1:0] mask_flat;

  assign now_flat = {now_month, now_date, now_wday, now_hour, now_min, now_sec};
  assign clr_vec  = (wr_en && (wr_addr == ADDR_W'(STAT_ADDR))) ? wr_data[N_ALARMS-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= PIN_IRQ;
      ien_q  <= '0;
    end else if (wr_en && (wr_addr == ADDR_W'(CFG_ADDR))) begin
      mode_q <= pin_mode_e'(wr_data[0]);
      ien_q  <= wr_data[N_ALARMS:1];
    end
  end

  for (genvar k = 0; k < N_ALARMS; k++) begin : g_alarm
    cal_alarm_unit #(.IDX(k), .ADDR_W(ADDR_W)) u_unit (
      .clk      (clk),
      .rst      (rst),
      .tick     (sec_tick),
      .now_flat (now_flat),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .clr_req  (clr_vec[k]),
      .flag     (alarm_flag[k]),
      .armed    (alarm_armed[k]),
      .rpt      (rpt_vec[k]),
      .mask     (mask_flat[k*N_FIELDS +: N_FIELDS])
    );
  end

  cal_pin_drive #(.N_ALARMS(N_ALARMS)) u_pin (
    .clk     (clk),
    .rst     (rst),
    .mode    (mode_q),
    .flags   (alarm_flag),
    .ien     (ien_q),
    .freq_in (freq_in),
    .pin_n   (irq_fout_n)
  );
endmodule

// File: rtl/cal_alarm_chk.sv
module cal_alarm_chk
  import cal_alarm_pkg::*;
#(
  parameter int N_ALARMS = 2,
  parameter int ADDR_W   = 5
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         sec_tick,
  input logic                         wr_en,
  input logic [ADDR_W-1:0]            wr_addr,
  input logic [7:0]                   wr_data,
  input logic                         freq_in,
  input logic                         irq_fout_n,
  input logic [N_ALARMS-1:0]          alarm_flag,
  input logic [N_ALARMS-1:0]          alarm_armed,
  input logic [N_ALARMS-1:0]          rpt_vec,
  input logic [N_ALARMS*N_FIELDS-1:0] mask_flat,
  input pin_mode_e                    mode_q
);
  localparam int STAT_ADDR = (N_ALARMS << OFF_W) + 1;

  for (genvar k = 0; k < N_ALARMS; k++) begin : g_chk
    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      (alarm_flag[k] && !(wr_en && wr_addr == ADDR_W'(STAT_ADDR) && wr_data[k]))
      |=> alarm_flag[k]);
    // R3
    flag_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(alarm_flag[k]) |-> $past(sec_tick));
    // R4
    empty_mask_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(alarm_flag[k]) |-> ($past(mask_flat[k*N_FIELDS +: N_FIELDS]) != '0));
    // R5
    oneshot_disarm_chk: assert property (@(posedge clk) disable iff (rst)
      ($rose(alarm_flag[k]) && !$past(rpt_vec[k]) && !$past(wr_en)) |-> !alarm_armed[k]);
    // R10
    armed_needed_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(alarm_flag[k]) |-> $past(alarm_armed[k]));
  end

  // R7
  irq_release_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_q) == PIN_IRQ && !$past(|alarm_flag)) |-> irq_fout_n);
  // R8
  freq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(mode_q) == PIN_FREQ) |-> (irq_fout_n == $past(freq_in)));
endmodule

bind cal_alarm_top cal_alarm_chk #(.N_ALARMS(N_ALARMS), .ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .sec_tick    (sec_tick),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .freq_in     (freq_in),
  .irq_fout_n  (irq_fout_n),
  .alarm_flag  (alarm_flag),
  .alarm_armed (alarm_armed),
  .rpt_vec     (rpt_vec),
  .mask_flat   (mask_flat),
  .mode_q      (mode_q)
);

// File: tb/cal_alarm_top_bench.sv
module cal_alarm_top_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sec_tick = 1'b0;
  logic [7:0] now_b [6];
  logic       wr_en = 1'b0;
  logic [4:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       freq_in = 1'b0;
  logic       irq_fout_n;
  logic [1:0] alarm_flag;
  logic [1:0] alarm_armed;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cal_alarm_top u_cal_alarm_top (
    .clk(clk), .rst(rst), .sec_tick(sec_tick),
    .now_sec(now_b[0]), .now_min(now_b[1]), .now_hour(now_b[2]),
    .now_wday(now_b[3]), .now_date(now_b[4]), .now_month(now_b[5]),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .freq_in(freq_in),
    .irq_fout_n(irq_fout_n), .alarm_flag(alarm_flag), .alarm_armed(alarm_armed)
  );

  function automatic logic [7:0] bcd(int n);
    return {4'(n / 10), 4'(n % 10)};
  endfunction

  function automatic logic [7:0] cmpval(int k, int f);
    return bcd((f * 7 + 3 + k * 13) % 29 + 1);
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
  endtask

  task automatic load_cmp(int k);
    for (int f = 0; f < 6; f++) wr(k * 8 + f, cmpval(k, f));
  endtask

  task automatic set_now(int k, logic [5:0] diff);
    for (int f = 0; f < 6; f++)
      now_b[f] = diff[f] ? cmpval(k, f) + 8'd1 : cmpval(k, f);
  endtask

  initial begin
    for (int f = 0; f < 6; f++) now_b[f] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 flags", {6'b0, alarm_flag}, 8'h0);
    chk("R1 armed", {6'b0, alarm_armed}, 8'h0);
    chk("R1 pin", {7'b0, irq_fout_n}, 8'h1);

    // R2 R3 R4 R7: sweep every mask against several mismatch patterns
    load_cmp(0);
    load_cmp(1);
    wr(16, 8'b0000_0010);
    for (int m = 0; m < 64; m++) begin
      wr(6, m | 8'hC0);
      for (int t = 0; t < 5; t++) begin
        logic [5:0] diff;
        logic       exp;
        diff = (t == 0) ? 6'd0 : 6'((m * 5 + t * 11 + t * t) & 63);
        if (t == 4) diff = ~6'(m);
        exp = (m != 0) && ((6'(m) & diff) == 6'd0);
        set_now(0, diff);
        tick();
        chk(m == 0 ? "R4 empty mask" : "R3 match", {7'b0, alarm_flag[0]}, {7'b0, exp});
        @(negedge clk);
        chk("R7 pin", {7'b0, irq_fout_n}, {7'b0, ~exp});
        chk("R9 other idle", {7'b0, alarm_flag[1]}, 8'h0);
        wr(17, 8'h01);
      end
    end
    chk("R6 cleared", {6'b0, alarm_flag}, 8'h0);

    // R3 no strobe, no fire
    set_now(0, 6'd0);
    wr(6, 8'hC1);
    repeat (4) @(negedge clk);
    chk("R3 no tick", {7'b0, alarm_flag[0]}, 8'h0);

    // R5 single-shot
    wr(6, 8'h81);
    tick();
    chk("R5 oneshot fire", {7'b0, alarm_flag[0]}, 8'h1);
    chk("R5 disarm", {7'b0, alarm_armed[0]}, 8'h0);
    wr(17, 8'h01);
    tick();
    chk("R5 no refire", {7'b0, alarm_flag[0]}, 8'h0);
    // R5 repeat
    wr(6, 8'hC1);
    tick();
    wr(17, 8'h01);
    tick();
    chk("R5 repeat refire", {7'b0, alarm_flag[0]}, 8'h1);
    chk("R5 repeat armed", {7'b0, alarm_armed[0]}, 8'h1);

    // R6 sticky, set wins over clear
    set_now(0, 6'h3F);
    repeat (3) tick();
    chk("R6 sticky", {7'b0, alarm_flag[0]}, 8'h1);
    wr(17, 8'h02);
    chk("R6 clr other bit", {7'b0, alarm_flag[0]}, 8'h1);
    set_now(0, 6'd0);
    @(negedge clk);
    sec_tick = 1'b1; wr_en = 1'b1; wr_addr = 5'd17; wr_data = 8'h01;
    @(negedge clk);
    sec_tick = 1'b0; wr_en = 1'b0;
    chk("R6 set wins", {7'b0, alarm_flag[0]}, 8'h1);
    wr(17, 8'h01);
    chk("R6 w1c", {7'b0, alarm_flag[0]}, 8'h0);

    // R10 disarmed
    wr(6, 8'h41);
    tick();
    chk("R10 disarmed", {7'b0, alarm_flag[0]}, 8'h0);

    // R9 channel 1 independent; R7 enable gating
    wr(14, 8'h9F);
    set_now(1, 6'd0);
    tick();
    chk("R9 ch1 fire", {6'b0, alarm_flag}, 8'h2);
    @(negedge clk);
    chk("R7 ch1 not enabled", {7'b0, irq_fout_n}, 8'h1);
    wr(16, 8'b0000_0100);
    @(negedge clk);
    chk("R7 ch1 enabled", {7'b0, irq_fout_n}, 8'h0);
    chk("R9 ch0 armed kept", {7'b0, alarm_armed[0]}, 8'h0);

    // R8 frequency mode
    wr(16, 8'b0000_0101);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      freq_in = i[0];
      @(negedge clk);
      chk("R8 follow", {7'b0, irq_fout_n}, {7'b0, i[0]});
    end
    wr(17, 8'h02);
    wr(14, 8'hDF);
    tick();
    chk("R8 flag updates", {7'b0, alarm_flag[1]}, 8'h1);
    @(negedge clk);
    freq_in = 1'b1;
    @(negedge clk);
    chk("R8 pin not irq", {7'b0, irq_fout_n}, 8'h1);
    wr(16, 8'b0000_0100);
    @(negedge clk);
    chk("R7 back to irq", {7'b0, irq_fout_n}, 8'h0);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule